// File: doc/BRIEF.md
# Quad Wiper Register I2C Slave

This block is an I2C target that holds four 8-bit volatile setting registers. Each register drives the tap select of one digitally controlled resistor string outside the block. It takes the raw SCL and SDA levels, sampled on the system clock. A short-pulse filter sits in front of START, STOP and bit-edge detection. The block pulls SDA low through an open-drain enable whenever it acknowledges or sends a zero bit.

A host writes a register with START, a write identification byte, a register index byte, one value byte and STOP. To read, the host sends the index in a write framing, then a repeated START and a read identification byte. The slave then streams register values from the selected index. The index advances after every byte and wraps from the last register to register 0 for as long as the host keeps acknowledging. Two strap inputs form part of the slave's identity. A standby output is high whenever the slave is idle and waiting for a START.

Top module: `wiper_bank_i2c`

## Requirements
- R1: After reset all four registers hold 80h, the SDA pull-down is released and standby is high.
- R2: An identification byte is accepted only if bits 7..3 are 01010 and bits 2..1 equal `strapA[1:0]`. Bit 0 selects the direction: 0 is write, 1 is read. An accepted byte is acknowledged by pulling SDA low on the ninth clock. A rejected byte gets no acknowledge, and the slave ignores the bus until the next START or STOP.
- R3: A write (START, identification with bit 0 = 0, index, value, STOP) acknowledges all three bytes. It places the value in the indexed register and leaves the other registers untouched.
- R4: Index values 00h..03h select registers 0..3. A larger index is not acknowledged and changes no register.
- R5: A read sends the index in a write framing, then a repeated START and an identification byte with bit 0 = 1. The slave acknowledges that byte and then sends the indexed register MSB first. SDA changes only while SCL is low.
- R6: After each sent byte the index advances by one, wrapping from 03h to 00h. Sending continues while the host acknowledges the ninth bit. When the host does not acknowledge, SDA is released.
- R7: Value bytes after the first one in a write are not acknowledged and change no register.
- R8: A START or STOP in the middle of a byte abandons the transfer without updating any register. A START is then treated as the beginning of a new transfer.
- R9: Standby is high after a STOP and low from an accepted START until the next STOP. The slave never pulls SDA while in standby.
- R10: Any START seen during the first `POWERUP_CYC` clocks after reset is ignored, so the following bytes get no acknowledge and change nothing.
- R11: A level change on SCL or SDA that lasts fewer than `FILT_LEN` clock samples is suppressed before edge detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL level from the pad |
| sdaIn | input | 1 | Raw SDA level from the pad (wired bus value) |
| strapA | input | 2 | Strap levels compared with identification bits 2..1 |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| wiperVal | output | NUM_WIPERS*8 | Register values, register k in bits 8k+7..8k |
| standby | output | 1 | High while idle and waiting for a START |

## Verification
The hardest case to reach from the pins is a START that arrives while the power-up window is still open. The bench drops SDA a handful of clocks after reset is released, with SCL still high. It then clocks a complete write that would be valid if the START had counted, and checks that no acknowledge appears and no register moves. The second hard case is the read pointer wrapping inside one read burst. It is reached by starting a five-byte read at index 2, so the stream crosses from register 3 back to register 0 and returns to register 2. The third hard case is filter rejection in the middle of a transfer. Every SCL-high phase of one value byte carries a two-sample SDA pulse that would otherwise decode as a START or a STOP.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] ID_PREFIX = 5'b01010;
  localparam logic [BYTE_W-1:0] WIPER_MID = 8'h80;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_ADDR, S_WDATA, S_ACK, S_TX, S_RACK, S_IGN
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rxShift;
    logic ptrLoad;
    logic ptrInc;
    logic wrEn;
    logic txLoad;
    logic txShift;
  } dp_cmd_t;

  // bus events decoded from the filtered lines
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
  } bus_ev_t;
endpackage

// File: rtl/wiper_line_filter.sv
module wiper_line_filter
  import wiper_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  output bus_ev_t ev,
  output logic    sdaLvl
);
  localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

  logic [1:0] rawIn;
  logic [1:0] filt;
  logic       sclPrev;
  logic       sdaPrev;

  assign rawIn = {sdaIn, sclIn};

  // line 0 is SCL, line 1 is SDA; same synchronizer and filter on both
  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [1:0]       syncQ;
    logic             lvlQ;
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= 2'b11;
        lvlQ  <= 1'b1;
        cntQ  <= '0;
      end else begin
        syncQ <= {syncQ[0], rawIn[i]};
        if (syncQ[1] == lvlQ) begin
          cntQ <= '0;
        end else if (cntQ == CNT_W'(FILT_LEN - 1)) begin
          lvlQ <= syncQ[1];
          cntQ <= '0;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end

    assign filt[i] = lvlQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= filt[0];
      sdaPrev <= filt[1];
    end
  end

  always_comb begin
    ev.start   = sclPrev & filt[0] & sdaPrev & ~filt[1];
    ev.stop    = sclPrev & filt[0] & ~sdaPrev & filt[1];
    ev.sclRise = ~sclPrev & filt[0];
    ev.sclFall = sclPrev & ~filt[0];
  end

  assign sdaLvl = filt[1];
endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter int NUM_WIPERS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dp_cmd_t                      cmd,
  input  logic                         sdaLvl,
  output logic [BYTE_W-1:0]            rxByte,
  output logic                         txMsb,
  output logic [NUM_WIPERS*BYTE_W-1:0] wiperFlat
);
  localparam int PTR_W = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1;

  logic [BYTE_W-1:0] rxQ;
  logic [BYTE_W-1:0] txQ;
  logic [PTR_W-1:0]  ptrQ;
  logic [BYTE_W-1:0] wiperArr [NUM_WIPERS];

  // receive shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxQ <= '0;
    else if (cmd.rxShift) rxQ <= {rxQ[BYTE_W-2:0], sdaLvl};
  end

  // register index with wrap at the last register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (cmd.ptrLoad) begin
      ptrQ <= rxQ[PTR_W-1:0];
    end else if (cmd.ptrInc) begin
      if (ptrQ == PTR_W'(NUM_WIPERS - 1)) ptrQ <= '0;
      else ptrQ <= ptrQ + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_WIPERS; k++) begin : g_wiper
    logic [BYTE_W-1:0] regQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ <= WIPER_MID;
      else if (cmd.wrEn && ptrQ == PTR_W'(k)) regQ <= rxQ;
    end
    assign wiperArr[k] = regQ;
    assign wiperFlat[k*BYTE_W +: BYTE_W] = regQ;
  end

  // transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txQ <= '1;
    else if (cmd.txLoad) txQ <= wiperArr[ptrQ];
    else if (cmd.txShift) txQ <= {txQ[BYTE_W-2:0], 1'b1};
  end

  assign rxByte = rxQ;
  assign txMsb  = txQ[BYTE_W-1];
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int NUM_WIPERS  = 4,
  parameter int POWERUP_CYC = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  bus_ev_t           ev,
  input  logic              sdaLvl,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic [1:0]        strapA,
  output dp_cmd_t           cmd,
  output logic              sdaPullLow,
  output logic              standby
);
  localparam int PU_W = (POWERUP_CYC < 1) ? 1 : $clog2(POWERUP_CYC + 1);
  localparam logic [3:0] BIT_DONE = 4'(BYTE_W);

  ctrl_state_e stateQ, stateD;
  ctrl_state_e ackNextQ, ackNextD;
  logic [3:0]  bitCntQ, bitCntD;
  logic        mAckQ, mAckD;
  logic [PU_W-1:0] puCntQ;
  logic        puBusy;
  logic        idOk;
  logic        addrOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) puCntQ <= PU_W'(POWERUP_CYC);
    else if (puCntQ != '0) puCntQ <= puCntQ - 1'b1;
  end
  assign puBusy = (puCntQ != '0);

  assign idOk   = (rxByte[7:3] == ID_PREFIX) && (rxByte[2:1] == strapA);
  assign addrOk = (int'(rxByte) < NUM_WIPERS);

  always_comb begin
    stateD   = stateQ;
    ackNextD = ackNextQ;
    bitCntD  = bitCntQ;
    mAckD    = mAckQ;
    cmd      = '0;
    if (ev.stop) begin
      stateD  = S_IDLE;
      bitCntD = '0;
    end else if (ev.start && !puBusy) begin
      stateD  = S_DEV;
      bitCntD = '0;
    end else begin
      case (stateQ)
        S_DEV, S_ADDR, S_WDATA: begin
          if (ev.sclRise && bitCntQ != BIT_DONE) begin
            cmd.rxShift = 1'b1;
            bitCntD     = bitCntQ + 1'b1;
          end else if (ev.sclFall && bitCntQ == BIT_DONE) begin
            bitCntD = '0;
            stateD  = S_IGN;
            if (stateQ == S_DEV) begin
              if (idOk) begin
                stateD   = S_ACK;
                ackNextD = rxByte[0] ? S_TX : S_ADDR;
              end
            end else if (stateQ == S_ADDR) begin
              if (addrOk) begin
                cmd.ptrLoad = 1'b1;
                stateD      = S_ACK;
                ackNextD    = S_WDATA;
              end
            end else begin
              cmd.wrEn = 1'b1;
              stateD   = S_ACK;
              ackNextD = S_IGN;
            end
          end
        end
        S_ACK: begin
          if (ev.sclFall) begin
            stateD  = ackNextQ;
            bitCntD = '0;
            if (ackNextQ == S_TX) cmd.txLoad = 1'b1;
          end
        end
        S_TX: begin
          if (ev.sclRise) begin
            bitCntD = bitCntQ + 1'b1;
          end else if (ev.sclFall) begin
            if (bitCntQ == BIT_DONE) begin
              stateD     = S_RACK;
              cmd.ptrInc = 1'b1;
              bitCntD    = '0;
            end else begin
              cmd.txShift = 1'b1;
            end
          end
        end
        S_RACK: begin
          if (ev.sclRise) begin
            mAckD = ~sdaLvl;
          end else if (ev.sclFall) begin
            if (mAckQ) begin
              stateD     = S_TX;
              cmd.txLoad = 1'b1;
            end else begin
              stateD = S_IGN;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      ackNextQ <= S_IGN;
      bitCntQ  <= '0;
      mAckQ    <= 1'b0;
    end else begin
      stateQ   <= stateD;
      ackNextQ <= ackNextD;
      bitCntQ  <= bitCntD;
      mAckQ    <= mAckD;
    end
  end

  assign sdaPullLow = (stateQ == S_ACK) || (stateQ == S_TX && !txMsb);
  assign standby    = (stateQ == S_IDLE);
endmodule

// File: rtl/wiper_bank_i2c.sv
module wiper_bank_i2c
  import wiper_pkg::*;
#(
  parameter int NUM_WIPERS  = 4,
  parameter int FILT_LEN    = 3,
  parameter int POWERUP_CYC = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sclIn,
  input  logic                         sdaIn,
  input  logic [1:0]                   strapA,
  output logic                         sdaPullLow,
  output logic [NUM_WIPERS*BYTE_W-1:0] wiperVal,
  output logic                         standby
);
  bus_ev_t           busEv;
  dp_cmd_t           dpCmd;
  logic              sdaLvl;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb;

  wiper_line_filter #(.FILT_LEN(FILT_LEN)) uFilt (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ev(busEv), .sdaLvl(sdaLvl)
  );

  wiper_ctrl #(.NUM_WIPERS(NUM_WIPERS), .POWERUP_CYC(POWERUP_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .ev(busEv), .sdaLvl(sdaLvl), .rxByte(rxByte),
    .txMsb(txMsb), .strapA(strapA), .cmd(dpCmd), .sdaPullLow(sdaPullLow),
    .standby(standby)
  );

  wiper_datapath #(.NUM_WIPERS(NUM_WIPERS)) uDp (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .sdaLvl(sdaLvl), .rxByte(rxByte),
    .txMsb(txMsb), .wiperFlat(wiperVal)
  );
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
  parameter int NUM_WIPERS  = 4,
  parameter int POWERUP_CYC = 64
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    sclIn,
  input logic                    sdaPullLow,
  input logic                    standby,
  input logic [NUM_WIPERS*8-1:0] wiperFlat
);
  localparam int PU_W = (POWERUP_CYC < 1) ? 1 : $clog2(POWERUP_CYC + 1);

  logic [PU_W-1:0]         upCnt;
  logic [NUM_WIPERS*8-1:0] prevQ;
  logic [NUM_WIPERS-1:0]   chg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCnt <= '0;
      prevQ <= {NUM_WIPERS{8'h80}};
    end else begin
      if (upCnt != PU_W'(POWERUP_CYC)) upCnt <= upCnt + 1'b1;
      prevQ <= wiperFlat;
    end
  end

  for (genvar k = 0; k < NUM_WIPERS; k++) begin : g_chg
    assign chg[k] = (wiperFlat[k*8 +: 8] != prevQ[k*8 +: 8]);
  end

  // R9: no pull-down while idle
  a_r9_idle_releases_sda: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> !sdaPullLow);

  // R3: registers move only inside a transfer
  a_r3_change_in_transfer: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wiperFlat) |-> !standby);

  // R3: one register per update at most
  a_r3_single_register: assert property (@(posedge clk) disable iff (!rstN)
    $countones(chg) <= 1);

  // R5: slave's SDA drive only moves while SCL is low
  a_r5_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclIn);

  // R10: stays idle through the power-up window
  a_r10_powerup_idle: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt < PU_W'(POWERUP_CYC)) |-> standby);
endmodule

bind wiper_bank_i2c wiper_bank_chk #(
  .NUM_WIPERS(NUM_WIPERS), .POWERUP_CYC(POWERUP_CYC)
) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .standby(standby), .wiperFlat(wiperVal)
);

// File: tb/tb_wiper_bank_i2c.sv
`timescale 1ns/1ps
module tb_wiper_bank_i2c;
  localparam int Q = 8;
  localparam logic [7:0] ID_W   = 8'h54;  // 01010 10 0
  localparam logic [7:0] ID_R   = 8'h55;  // 01010 10 1
  localparam logic [7:0] ID_BADSTRAP = 8'h52; // 01010 01 0
  localparam logic [7:0] ID_BADPFX   = 8'h5C; // 01011 10 0

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sdaLine;
  logic sdaPullLow;
  logic [31:0] wiperVal;
  logic standby;

  assign sdaLine = sdaM & ~sdaPullLow;

  wiper_bank_i2c dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .strapA(strap),
    .sdaPullLow(sdaPullLow), .wiperVal(wiperVal), .standby(standby)
  );

  int nChk = 0;
  int nFail = 0;
  bit cmpEn = 1'b0;
  bit done = 1'b0;
  logic [7:0] expW [4];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] packExp();
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = expW[k];
    return r;
  endfunction

  // reference model compared every clock while the bus is quiet
  always @(negedge clk) begin
    if (cmpEn && rstN) begin
      chk(wiperVal == packExp(), "R3 model registers", wiperVal, packExp());
      chk(standby == 1'b1, "R9 idle standby", 32'(standby), 32'd1);
    end
  end

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitC(Q);
    sclM = 1'b1; waitC(Q);
    sdaM = 1'b0; waitC(Q);
    sclM = 1'b0; waitC(Q);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitC(Q);
    sclM = 1'b1; waitC(Q);
    sdaM = 1'b1; waitC(2*Q);
  endtask

  task automatic beginTx();
    cmpEn = 1'b0;
    startCond();
  endtask

  task automatic endTx();
    stopCond();
    waitC(2*Q);
    cmpEn = 1'b1;
  endtask

  task automatic sendBit(input logic b, input bit glitch);
    sdaM = b; waitC(Q);
    sclM = 1'b1;
    if (glitch) begin
      waitC(Q/2);
      sdaM = ~b; waitC(2);
      sdaM = b;  waitC(2*Q - Q/2 - 2);
    end else begin
      waitC(2*Q);
    end
    sclM = 1'b0; waitC(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i], glitch);
    sdaM = 1'b1; waitC(Q);
    sclM = 1'b1; waitC(Q);
    ack = !sdaLine;
    waitC(Q);
    sclM = 1'b0; waitC(Q);
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitC(Q);
      sclM = 1'b1; waitC(Q);
      v[i] = sdaLine;
      waitC(Q);
      sclM = 1'b0; waitC(Q);
    end
    sdaM = !giveAck; waitC(Q);
    sclM = 1'b1; waitC(2*Q);
    sclM = 1'b0; waitC(Q);
    sdaM = 1'b1;
  endtask

  task automatic doWrite(input logic [7:0] id, input logic [7:0] idx, input logic [7:0] val,
                         output bit a0, output bit a1, output bit a2);
    beginTx();
    sendByte(id, 1'b0, a0);
    sendByte(idx, 1'b0, a1);
    sendByte(val, 1'b0, a2);
  endtask

  initial begin
    bit a0, a1, a2, ack;
    logic [7:0] rd;
    for (int k = 0; k < 4; k++) expW[k] = 8'h80;
    waitC(5);
    rstN = 1'b1;
    waitC(1);
    chk(wiperVal == 32'h80808080, "R1 reset registers", wiperVal, 32'h80808080);
    chk(sdaPullLow == 1'b0, "R1 sda released", 32'(sdaPullLow), 32'd0);
    chk(standby == 1'b1, "R1 standby", 32'(standby), 32'd1);
    cmpEn = 1'b1;

    // R10: START inside the power-up window, then a full write
    sdaM = 1'b0; waitC(Q);
    sclM = 1'b0; waitC(Q);
    sendByte(ID_W, 1'b0, ack);
    chk(ack == 1'b0, "R10 id ignored", 32'(ack), 32'd0);
    sendByte(8'h01, 1'b0, ack);
    sendByte(8'h12, 1'b0, ack);
    chk(ack == 1'b0, "R10 data ignored", 32'(ack), 32'd0);
    stopCond();
    waitC(2*Q);

    // R2, R3, R9: write register 1
    beginTx();
    sendByte(ID_W, 1'b0, a0);
    chk(a0 == 1'b1, "R2 id ack", 32'(a0), 32'd1);
    chk(standby == 1'b0, "R9 busy standby", 32'(standby), 32'd0);
    sendByte(8'h01, 1'b0, a1);
    chk(a1 == 1'b1, "R3 index ack", 32'(a1), 32'd1);
    sendByte(8'h3C, 1'b0, a2);
    chk(a2 == 1'b1, "R3 value ack", 32'(a2), 32'd1);
    expW[1] = 8'h3C;
    endTx();
    chk(wiperVal == packExp(), "R3 write reg1", wiperVal, packExp());

    // R3 boundaries: 00h into reg0, FFh into reg2
    doWrite(ID_W, 8'h00, 8'h00, a0, a1, a2);
    chk(a2 == 1'b1, "R3 value ack reg0", 32'(a2), 32'd1);
    expW[0] = 8'h00;
    endTx();
    doWrite(ID_W, 8'h02, 8'hFF, a0, a1, a2);
    expW[2] = 8'hFF;
    endTx();
    chk(wiperVal == packExp(), "R3 boundary values", wiperVal, packExp());

    // R7: extra value byte is refused
    doWrite(ID_W, 8'h03, 8'h5A, a0, a1, a2);
    chk(a2 == 1'b1, "R7 first value ack", 32'(a2), 32'd1);
    sendByte(8'hA5, 1'b0, ack);
    chk(ack == 1'b0, "R7 extra value nack", 32'(ack), 32'd0);
    expW[3] = 8'h5A;
    endTx();
    chk(wiperVal[31:24] == 8'h5A, "R7 reg3 keeps first", 32'(wiperVal[31:24]), 32'h5A);

    // R2: strap mismatch and wrong prefix
    doWrite(ID_BADSTRAP, 8'h00, 8'h77, a0, a1, a2);
    chk(a0 == 1'b0, "R2 strap mismatch nack", 32'(a0), 32'd0);
    chk(a2 == 1'b0, "R2 ignored after mismatch", 32'(a2), 32'd0);
    endTx();
    doWrite(ID_BADPFX, 8'h00, 8'h77, a0, a1, a2);
    chk(a0 == 1'b0, "R2 prefix mismatch nack", 32'(a0), 32'd0);
    endTx();
    chk(wiperVal == packExp(), "R2 no change", wiperVal, packExp());

    // R4: index out of range
    doWrite(ID_W, 8'h04, 8'h66, a0, a1, a2);
    chk(a1 == 1'b0, "R4 index nack", 32'(a1), 32'd0);
    chk(a2 == 1'b0, "R4 value nack", 32'(a2), 32'd0);
    endTx();
    chk(wiperVal == packExp(), "R4 no change", wiperVal, packExp());

    // R8: STOP in the middle of a value byte
    beginTx();
    sendByte(ID_W, 1'b0, a0);
    sendByte(8'h01, 1'b0, a1);
    for (int i = 0; i < 4; i++) sendBit(1'b1, 1'b0);
    endTx();
    chk(wiperVal[15:8] == 8'h3C, "R8 stop abort", 32'(wiperVal[15:8]), 32'h3C);

    // R8: START in the middle of a value byte, then a new write
    beginTx();
    sendByte(ID_W, 1'b0, a0);
    sendByte(8'h02, 1'b0, a1);
    for (int i = 0; i < 5; i++) sendBit(1'b0, 1'b0);
    startCond();
    sendByte(ID_W, 1'b0, a0);
    chk(a0 == 1'b1, "R8 restart id ack", 32'(a0), 32'd1);
    sendByte(8'h00, 1'b0, a1);
    sendByte(8'h99, 1'b0, a2);
    expW[0] = 8'h99;
    endTx();
    chk(wiperVal == packExp(), "R8 start abort", wiperVal, packExp());

    // R5, R6: read from index 2 with wrap
    beginTx();
    sendByte(ID_W, 1'b0, a0);
    sendByte(8'h02, 1'b0, a1);
    startCond();
    sendByte(ID_R, 1'b0, ack);
    chk(ack == 1'b1, "R5 read id ack", 32'(ack), 32'd1);
    for (int n = 0; n < 5; n++) begin
      readByte(n != 4, rd);
      chk(rd == expW[(2 + n) % 4], "R6 read stream", 32'(rd), 32'(expW[(2 + n) % 4]));
    end
    waitC(Q);
    chk(sdaLine == 1'b1, "R6 sda released after nack", 32'(sdaLine), 32'd1);
    endTx();

    // R11: two-sample SDA pulses during every SCL-high of the value byte
    doWrite(ID_W, 8'h03, 8'h00, a0, a1, a2);
    endTx();
    expW[3] = 8'h00;
    beginTx();
    sendByte(ID_W, 1'b0, a0);
    sendByte(8'h03, 1'b0, a1);
    sendByte(8'hC3, 1'b1, a2);
    chk(a2 == 1'b1, "R11 value ack through glitches", 32'(a2), 32'd1);
    expW[3] = 8'hC3;
    endTx();
    chk(wiperVal[31:24] == 8'hC3, "R11 glitch rejected", 32'(wiperVal[31:24]), 32'hC3);

    done = 1'b1;
    cmpEn = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule